// File: doc/BRIEF.md
# Power-Good Window Supervisor

This block turns comparator flags into a qualified power-good indication for a switching regulator. Two flags report whether the divided-down feedback sits above the low limit (83% of the reference) and below the high limit (117% of the reference). A third flag reports whether the input supply is high enough for the logic to mean anything. A shutdown request starts an orderly release of the indication.

The good flag rises only after the feedback has stayed inside the window for a long qualification time (1.2 ms in the target system). If the window is left during that time, qualification starts again from zero. Once good, leaving the window drops the flag on the next clock. A shutdown request drops it after a short fixed delay (10 µs in the target system). Both lengths are parameters counted in clock cycles.

Besides the good flag, the block drives an active-high pull-down control for an open-drain pin. While the supply is too low, both outputs are released, because no valid indication can be given.

Top module: `pg_window_supervisor`

## Requirements
- R1: While reset is asserted, and after it until the first clock edge with reset released, pg_good and pg_pull_low are both 0.
- R2: The feedback counts as in-window only in a cycle where fb_over_low and fb_under_high are both 1. Either flag at 0 alone keeps pg_good at 0.
- R3: pg_good rises at the clock edge that samples the QUAL_CYCLES-th consecutive cycle with feedback in-window, shdn_req at 0 and vin_ok at 1.
- R4: A sample that is out of window during qualification restarts the count from zero. The full QUAL_CYCLES run must then be seen again.
- R5: While pg_good is 1, an out-of-window sample clears pg_good at that same clock edge, with no delay.
- R6: While pg_good is 1, the first sampled shdn_req of 1 starts a drain. pg_good stays 1 for exactly SHDN_CYCLES clock edges after that edge and falls at the SHDN_CYCLES-th one. Releasing shdn_req during the drain does not shorten or cancel it.
- R7: While pg_good is 0 and shdn_req is 1, no qualification progress is made and pg_good stays 0.
- R8: A sample with vin_ok at 0 clears pg_good and pg_pull_low at that edge and discards any qualification progress.
- R9: With vin_ok sampled at 1, pg_pull_low is the complement of pg_good. The two are never 1 together.
- R10: An out-of-window sample during the shutdown drain clears pg_good at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fb_over_low | input | 1 | Feedback above the low limit |
| fb_under_high | input | 1 | Feedback below the high limit |
| vin_ok | input | 1 | Input supply high enough for valid logic |
| shdn_req | input | 1 | Shutdown / disable request |
| pg_good | output | 1 | Qualified power-good indication |
| pg_pull_low | output | 1 | Pull-down control for the open-drain pin (1 = pull low) |

## Verification
Every result is registered once. A change in the inputs sampled at one rising edge therefore shows on both outputs right after that edge, and never later except through the counted delays. The rise comes at the QUAL_CYCLES-th qualifying edge and the drain ends SHDN_CYCLES edges after the first sampled request. The bench's model updates on the same edge from the same sampled inputs. The bench compares the outputs 2 ns after every rising edge, so each check lands in the cycle that the requirement names. Stimuli sit on exact boundaries: a break one cycle before the count would complete, the request released in the middle of a drain, and supply loss during qualification.

// File: rtl/pg_pkg.sv
package pg_pkg;

  typedef enum logic [1:0] {
    PG_OFF   = 2'd0,
    PG_QUAL  = 2'd1,
    PG_GOOD  = 2'd2,
    PG_DRAIN = 2'd3
  } pg_state_e;

  // counter width able to hold 0 .. n-1 for n >= 1
  function automatic int unsigned cnt_width(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) < n) w++;
    return w;
  endfunction

  // true when the current tick completes a window of len ticks
  function automatic logic tick_is_last(input int unsigned cnt, input int unsigned len);
    return cnt == (len - 1);
  endfunction

endpackage

// File: rtl/pg_window_decode.sv
module pg_window_decode (
  input  logic over_low,
  input  logic under_high,
  output logic in_win,
  output logic out_low,
  output logic out_high
);
  assign in_win   = over_low & under_high;
  assign out_low  = ~over_low;
  assign out_high = ~under_high;
endmodule

// File: rtl/pg_tick_timer.sv
module pg_tick_timer #(
  parameter int unsigned LIMIT = 16,
  localparam int unsigned CW   = pg_pkg::cnt_width(LIMIT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (inc)      cnt <= cnt + 1'b1;
  end

  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cnt) < LIMIT)); // R3
endmodule

// File: rtl/pg_seq_ctrl.sv
module pg_seq_ctrl
  import pg_pkg::*;
#(
  parameter int unsigned QUAL_CYCLES = 16,
  parameter int unsigned SHDN_CYCLES = 4,
  parameter int unsigned CW          = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vin_ok,
  input  logic          in_win,
  input  logic          shdn_req,
  input  logic [CW-1:0] cnt,
  output logic          tmr_clr,
  output logic          tmr_inc,
  output logic          tmr_last,
  output logic          good,
  output logic          pull_low
);
  pg_state_e state, nxt;
  logic qual_last, drain_last, qual_ok;

  assign qual_last  = tick_is_last(32'(cnt), QUAL_CYCLES);
  assign drain_last = tick_is_last(32'(cnt), SHDN_CYCLES);
  assign tmr_last   = (state == PG_DRAIN) ? drain_last : qual_last;
  assign qual_ok    = in_win & ~shdn_req;

  always_comb begin
    nxt     = state;
    tmr_clr = 1'b0;
    tmr_inc = 1'b0;
    if (!vin_ok) begin
      nxt     = PG_OFF;
      tmr_clr = 1'b1;
    end else begin
      unique case (state)
        PG_OFF, PG_QUAL: begin
          if (qual_ok && qual_last) begin
            nxt     = PG_GOOD;
            tmr_clr = 1'b1;
          end else if (qual_ok) begin
            nxt     = PG_QUAL;
            tmr_inc = 1'b1;
          end else begin
            nxt     = PG_QUAL;
            tmr_clr = 1'b1;
          end
        end
        PG_GOOD: begin
          tmr_clr = 1'b1;
          if (!in_win)       nxt = PG_QUAL;
          else if (shdn_req) nxt = PG_DRAIN;
        end
        PG_DRAIN: begin
          if (!in_win || drain_last) begin
            nxt     = PG_QUAL;
            tmr_clr = 1'b1;
          end else begin
            tmr_inc = 1'b1;
          end
        end
        default: begin
          nxt     = PG_OFF;
          tmr_clr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= PG_OFF;
    else        state <= nxt;
  end

  assign good     = (state == PG_GOOD) || (state == PG_DRAIN);
  assign pull_low = (state == PG_QUAL);

  AST_WINDOW_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (good && !in_win) |=> !good); // R5
  AST_NO_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    !vin_ok |=> (!good && !pull_low)); // R8
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(good && pull_low)); // R9
  AST_RISE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(good) |-> ($past(in_win) && !$past(shdn_req) && $past(tmr_last))); // R3
  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PG_DRAIN && in_win && vin_ok && !tmr_last) |=> good); // R6
  AST_SHDN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!good && shdn_req) |=> !good); // R7
endmodule

// File: rtl/pg_window_supervisor.sv
module pg_window_supervisor #(
  parameter int unsigned QUAL_CYCLES = 150000,
  parameter int unsigned SHDN_CYCLES = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fb_over_low,
  input  logic fb_under_high,
  input  logic vin_ok,
  input  logic shdn_req,
  output logic pg_good,
  output logic pg_pull_low
);
  localparam int unsigned LIMIT = (QUAL_CYCLES > SHDN_CYCLES) ? QUAL_CYCLES : SHDN_CYCLES;
  localparam int unsigned CW    = pg_pkg::cnt_width(LIMIT);

  logic          in_win, out_low, out_high;
  logic          tmr_clr, tmr_inc, tmr_last;
  logic [CW-1:0] cnt;

  pg_window_decode u_win (
    .over_low  (fb_over_low),
    .under_high(fb_under_high),
    .in_win    (in_win),
    .out_low   (out_low),
    .out_high  (out_high)
  );

  pg_tick_timer #(.LIMIT(LIMIT)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (tmr_clr),
    .inc  (tmr_inc),
    .cnt  (cnt)
  );

  pg_seq_ctrl #(
    .QUAL_CYCLES(QUAL_CYCLES),
    .SHDN_CYCLES(SHDN_CYCLES),
    .CW         (CW)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .vin_ok  (vin_ok),
    .in_win  (in_win),
    .shdn_req(shdn_req),
    .cnt     (cnt),
    .tmr_clr (tmr_clr),
    .tmr_inc (tmr_inc),
    .tmr_last(tmr_last),
    .good    (pg_good),
    .pull_low(pg_pull_low)
  );

  AST_WIN_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    in_win |-> (!out_low && !out_high)); // R2
endmodule

// File: tb/pg_window_supervisor_bench.sv
module pg_window_supervisor_bench;
  localparam int QUAL = 20;
  localparam int SHDN = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lo = 1'b0, hi = 1'b0, vin = 1'b0, sd = 1'b0;
  logic pg_good, pg_pull_low;

  always #4 clk = ~clk;

  pg_window_supervisor #(.QUAL_CYCLES(QUAL), .SHDN_CYCLES(SHDN)) u_pg_window_supervisor (
    .clk(clk), .rst_n(rst_n), .fb_over_low(lo), .fb_under_high(hi),
    .vin_ok(vin), .shdn_req(sd), .pg_good(pg_good), .pg_pull_low(pg_pull_low)
  );

  int    vectors = 0;
  int    errors  = 0;
  int    cycles  = 0;
  bit    done    = 0;
  string tag     = "R1";

  // behavioural reference
  bit ref_good = 0, ref_powered = 0, draining = 0;
  int run = 0, elapsed = 0;

  always @(posedge clk) begin
    bit win;
    win = lo && hi;
    if (!rst_n || !vin) begin
      ref_good = 0; ref_powered = 0; draining = 0; run = 0;
    end else begin
      ref_powered = 1;
      if (ref_good) begin
        if (!win) begin
          ref_good = 0; draining = 0; run = 0;
        end else if (draining) begin
          if (elapsed == SHDN) begin ref_good = 0; draining = 0; run = 0; end
          else elapsed++;
        end else if (sd) begin
          draining = 1; elapsed = 1;
        end
      end else if (win && !sd) begin
        run++;
        if (run == QUAL) begin ref_good = 1; run = 0; end
      end else begin
        run = 0;
      end
    end
    #2;
    if (!done) begin
      vectors++;
      if (pg_good !== ref_good) begin
        errors++;
        $display("FAIL %s: pg_good=%0b expected %0b at cycle %0d", tag, pg_good, ref_good, cycles);
      end
      if (pg_pull_low !== (ref_powered && !ref_good)) begin
        errors++;
        $display("FAIL %s: pg_pull_low=%0b expected %0b at cycle %0d", tag, pg_pull_low,
                 ref_powered && !ref_good, cycles);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not end, cycles=%0d expected <= 5000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic step(input string t, input logic l, input logic h, input logic v,
                      input logic s, input int n);
    @(negedge clk);
    tag = t; lo = l; hi = h; vin = v; sd = s;
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    step("R1", 1, 1, 1, 0, 4);
    rst_n = 1'b1;
    // R9: powered, out of window -> pull low
    step("R9", 0, 0, 1, 0, 5);
    // R2: only one flag set never qualifies
    step("R2", 1, 0, 1, 0, QUAL + 5);
    step("R2", 0, 1, 1, 0, QUAL + 5);
    // R4: break one short of completion, then restart
    step("R4", 1, 1, 1, 0, QUAL - 1);
    step("R4", 1, 0, 1, 0, 1);
    step("R4", 1, 1, 1, 0, QUAL - 1);
    // R3: complete a full run and hold
    step("R3", 1, 1, 1, 0, 6);
    // R5: single out-of-window sample drops at once
    step("R5", 0, 1, 1, 0, 1);
    step("R3", 1, 1, 1, 0, QUAL + 3);
    // R6: short request, released mid-drain
    step("R6", 1, 1, 1, 1, 2);
    step("R6", 1, 1, 1, 0, SHDN + 4);
    // R7: request held blocks qualification
    step("R7", 1, 1, 1, 1, QUAL + 10);
    step("R3", 1, 1, 1, 0, QUAL + 2);
    // R6: request held through the drain
    step("R6", 1, 1, 1, 1, SHDN + 3);
    step("R3", 1, 1, 1, 0, QUAL + 2);
    // R10: window exit during drain
    step("R10", 1, 1, 1, 1, 2);
    step("R10", 1, 0, 1, 1, 3);
    // R8: supply loss during qualification and while good
    step("R8", 1, 1, 1, 0, QUAL / 2);
    step("R8", 1, 1, 0, 0, 3);
    step("R8", 1, 1, 1, 0, QUAL + 3);
    step("R8", 1, 1, 0, 0, 4);
    step("R9", 0, 0, 1, 0, 4);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule